// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-driven SPI master for serial flash devices. Software loads a command word that holds the opcode and a 24-bit flash address. It loads a 32-bit data word and then writes a control word. The control word carries a transmit byte count, a receive byte count and a start bit. The engine pulls chip select low and shifts out the opcode, then the address bytes, then the write-data bytes, up to the transmit count. It then clocks in the requested number of response bytes and drops busy.

Every transfer is half duplex: no bit is sent and received in the same SCK period. Write data and read data share one 32-bit data register. Both use little-endian byte lanes. Only SPI mode 0 and a single slave are served. The serial clock is the system clock divided by the even parameter `DIV`, whose default is 4. The register port is a plain single-cycle 32-bit write/read interface with combinational read data.

Top module: `flash_cmd_spi`

## Requirements
- R1: After synchronous reset the command, data and control registers read 0, spi_cs_n is 1 and spi_sck is 0.
- R2: The command register (address 0) holds the opcode in bits [7:0] and the flash address in bits [31:8]. The serial byte order is: opcode; address bits [23:16], [15:8], [7:0]; data lane 0 up to lane 3. Only the first tx-count bytes of this order are sent.
- R3: The control register is at address 2. The tx count in bits [3:0] counts every sent byte, so it includes the opcode, address and data bytes and ranges from 1 to 8. The rx count in bits [10:8] ranges from 0 to 4.
- R4: Transmitted data byte i is taken from data register (address 1) bits [8i+7:8i].
- R5: Received byte i is stored in data bits [8i+7:8i]. Lanes at or above the rx count keep their previous value.
- R6: Receive bits are clocked only after all transmit bits. MISO is ignored during the transmit bytes. A frame holds exactly 8*(tx+rx) SCK pulses.
- R7: SPI mode 0 is used. SCK idles low, bits go MSB first, MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge.
- R8: spi_cs_n stays low for the whole frame. Between frames it stays high for at least DIV system clocks.
- R9: Each SCK bit lasts DIV system clocks, with DIV/2 high and DIV/2 low.
- R10: Writing control bit 16 as 1 starts a transfer. Busy (control bit 17) reads 1 from the next cycle until the frame and its gap are over. Bit 16 always reads 0.
- R11: A start is refused, and busy stays 0, when any of these holds: the mode field bits [21:20] is non-zero; the slave field bit 24 is 1; the tx count is 0 or above 8; the rx count is above 4.
- R12: Register writes made while busy have no effect on any register and do not start a frame.
- R13: After completion the tx and rx count fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 data, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a running frame. Such a write must change nothing, and any restart it carries must produce no second frame. The stimulus waits a few cycles into a long eight-byte or mixed frame and then writes the data, command and control registers, the control write carrying a start. The scoreboard flags any frame it did not expect, and the read-backs after completion expose any register the write corrupted. The data register is pre-seeded with distinct lanes, so the value read back shows whether a partial receive left the upper lanes alone.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

    localparam int START_BIT = 16;
    localparam int BUSY_BIT  = 17;
    localparam int MAX_TX    = 8;
    localparam int MAX_RX    = 4;
    localparam int BITW      = 7;   // bit index width, up to 96 bits per frame

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} phase_e;

    typedef struct packed {
        logic [3:0] txc;
        logic [2:0] rxc;
        logic [1:0] mode;
        logic       slave;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.txc   = w[3:0];
        c.rxc   = w[10:8];
        c.mode  = w[21:20];
        c.slave = w[24];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c, input logic busy);
        logic [31:0] w;
        w           = '0;
        w[3:0]      = c.txc;
        w[10:8]     = c.rxc;
        w[BUSY_BIT] = busy;
        w[21:20]    = c.mode;
        w[24]       = c.slave;
        return w;
    endfunction

    function automatic logic ctrl_legal(input ctrl_t c);
        return (c.mode == 2'd0) && !c.slave && (c.txc != 4'd0) &&
               (c.txc <= 4'(MAX_TX)) && (c.rxc <= 3'(MAX_RX));
    endfunction

    // Serial order, first bit at [63]
    function automatic logic [63:0] tx_order(input logic [31:0] cmd, input logic [31:0] data);
        return {cmd[7:0], cmd[31:24], cmd[23:16], cmd[15:8],
                data[7:0], data[15:8], data[23:16], data[31:24]};
    endfunction

    function automatic logic [BITW-1:0] frame_bits(input ctrl_t c);
        logic [3:0] bytes;
        bytes = c.txc + {1'b0, c.rxc};
        return {bytes, 3'b000};
    endfunction
endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
    import fcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            busy,
    input  logic            rx_valid,
    input  logic [1:0]      rx_lane,
    input  logic [7:0]      rx_byte,
    output logic            launch,
    output logic [63:0]     stream,
    output logic [BITW-1:0] tx_bits,
    output logic [BITW-1:0] total_bits
);
    logic [31:0] cmd_q;
    logic [31:0] data_q;
    ctrl_t       ctrl_q;
    ctrl_t       ctrl_in;
    logic        wr_ok;

    assign wr_ok      = reg_we && !busy;
    assign ctrl_in    = ctrl_unpack(reg_wdata);
    assign launch     = wr_ok && (reg_addr == A_CTRL) && reg_wdata[START_BIT] && ctrl_legal(ctrl_in);
    assign stream     = tx_order(cmd_q, data_q);
    assign tx_bits    = {ctrl_in.txc, 3'b000};
    assign total_bits = frame_bits(ctrl_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_ok && reg_addr == A_CMD)
                cmd_q <= reg_wdata;
            if (wr_ok && reg_addr == A_CTRL)
                ctrl_q <= ctrl_in;
            if (wr_ok && reg_addr == A_DATA)
                data_q <= reg_wdata;
            else if (rx_valid)
                data_q[{rx_lane, 3'b000} +: 8] <= rx_byte;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CMD:   reg_rdata = cmd_q;
            A_DATA:  reg_rdata = data_q;
            A_CTRL:  reg_rdata = ctrl_pack(ctrl_q, busy);
            default: reg_rdata = '0;
        endcase
    end

    // R12: while busy only received bytes may change the registers
    a_r12_frozen_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !rx_valid) |=> ($stable(data_q) && $stable(cmd_q) && $stable(ctrl_q)));
endmodule

// File: rtl/fcs_sck_gen.sv
module fcs_sck_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sck,
    output logic rise,
    output logic fall
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(HALF - 1));
    assign rise = tick && !sck;
    assign fall = tick && sck;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)
                sck <= ~sck;
        end
    end

    // R7: clock returns low and stays low once the shifter stops
    a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sck);
endmodule

// File: rtl/fcs_shifter.sv
module fcs_shifter
    import fcs_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            launch,
    input  logic [63:0]     stream,
    input  logic [BITW-1:0] tx_bits,
    input  logic [BITW-1:0] total_bits,
    input  logic            sck,
    input  logic            rise,
    input  logic            fall,
    input  logic            miso,
    output logic            running,
    output logic            cs_n,
    output logic            mosi,
    output logic            busy,
    output logic            rx_valid,
    output logic [1:0]      rx_lane,
    output logic [7:0]      rx_byte
);
    localparam int GW = (DIV > 1) ? $clog2(DIV) : 1;

    phase_e          st;
    logic [63:0]     sh;
    logic [BITW-1:0] idx;
    logic [BITW-1:0] txb;
    logic [BITW-1:0] totb;
    logic [7:0]      rsh;
    logic [GW-1:0]   gap;
    logic            in_rx;
    logic [4:0]      rxoff;

    assign in_rx   = idx >= txb;
    assign rxoff   = idx[4:0] - txb[4:0];
    assign running = (st == ST_SHIFT);
    assign cs_n    = (st != ST_SHIFT);
    assign busy    = (st != ST_IDLE);
    assign mosi    = running && !in_rx && sh[63];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            sh       <= '0;
            idx      <= '0;
            txb      <= '0;
            totb     <= '0;
            rsh      <= '0;
            gap      <= '0;
            rx_valid <= 1'b0;
            rx_lane  <= '0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (launch) begin
                        st   <= ST_SHIFT;
                        sh   <= stream;
                        idx  <= '0;
                        txb  <= tx_bits;
                        totb <= total_bits;
                    end
                end
                ST_SHIFT: begin
                    if (rise && in_rx) begin
                        rsh <= {rsh[6:0], miso};
                        if (rxoff[2:0] == 3'd7) begin
                            rx_valid <= 1'b1;
                            rx_byte  <= {rsh[6:0], miso};
                            rx_lane  <= rxoff[4:3];
                        end
                    end
                    if (fall) begin
                        sh <= {sh[62:0], 1'b0};
                        if (idx == totb - 1'b1) begin
                            st  <= ST_GAP;
                            gap <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: begin
                    if (gap == GW'(DIV - 1))
                        st <= ST_IDLE;
                    else
                        gap <= gap + 1'b1;
                end
            endcase
        end
    end

    // R7: MOSI holds through every high phase of SCK
    a_r7_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));
    // R7: SCK is low whenever chip select is inactive
    a_r7_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);
    // R8: chip select never pulses low right after it rises
    a_r8_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);
endmodule

// File: rtl/flash_cmd_spi.sv
module flash_cmd_spi
    import fcs_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic            busy;
    logic            launch;
    logic [63:0]     stream;
    logic [BITW-1:0] tx_bits;
    logic [BITW-1:0] total_bits;
    logic            rx_valid;
    logic [1:0]      rx_lane;
    logic [7:0]      rx_byte;
    logic            running;
    logic            rise;
    logic            fall;

    fcs_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .rx_valid   (rx_valid),
        .rx_lane    (rx_lane),
        .rx_byte    (rx_byte),
        .launch     (launch),
        .stream     (stream),
        .tx_bits    (tx_bits),
        .total_bits (total_bits)
    );

    fcs_sck_gen #(.DIV(DIV)) u_sck (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .sck  (spi_sck),
        .rise (rise),
        .fall (fall)
    );

    fcs_shifter #(.DIV(DIV)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .stream     (stream),
        .tx_bits    (tx_bits),
        .total_bits (total_bits),
        .sck        (spi_sck),
        .rise       (rise),
        .fall       (fall),
        .miso       (spi_miso),
        .running    (running),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .busy       (busy),
        .rx_valid   (rx_valid),
        .rx_lane    (rx_lane),
        .rx_byte    (rx_byte)
    );

    // R10 and R11: busy only rises after a legal control write with start set
    a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_we && reg_addr == A_CTRL && reg_wdata[START_BIT]));
    a_r11_busy_needs_legal: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_legal(ctrl_unpack(reg_wdata))));
endmodule

// File: tb/flash_cmd_spi_test.sv
`timescale 1ns/1ps
module flash_cmd_spi_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b1;

    always #2 clk = ~clk;

    flash_cmd_spi #(.DIV(DIV)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    typedef struct { int ntx; int nrx; logic [63:0] s; } exp_t;
    exp_t exp_q[$];

    int cur_ntx = 1, cur_nrx = 0;
    logic [31:0] cur_resp = '0;
    int nd = 0, fd = 0, nm = 0, fm = 0;
    bit wd_fail = 0;

    task automatic report();
        int tot, bad;
        tot = nd + nm + (wd_fail ? 1 : 0);
        bad = fd + fm + (wd_fail ? 1 : 0);
        $display("%0d/%0d checks passed", tot - bad, tot);
    endtask

    task automatic chk_d(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nd++;
        if (!ok) begin fd++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
    endtask

    task automatic chk_m(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nm++;
        if (!ok) begin fm++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
    endtask

    function automatic logic [63:0] order(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d);
        return {op, a[23:16], a[15:8], a[7:0], d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic miso_bit(input int n);
        int k;
        if (n < cur_ntx * 8) return 1'b1;      // junk during transmit, must be ignored
        k = n - cur_ntx * 8;
        if (k >= cur_nrx * 8) return 1'b0;
        return cur_resp[8 * (k / 8) + 7 - (k % 8)];
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Monitor: samples the serial side away from the active edge, pops the scoreboard per frame
    initial begin
        logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0;
        logic [63:0] cap = '0;
        int bitn = 0, hi = 0, viol = 0, gapc = 0;
        bit seen = 0;
        exp_t it;
        forever begin
            @(negedge clk);
            if (rst) begin
                p_cs = 1'b1; p_sck = 1'b0; p_mosi = 1'b0;
                continue;
            end
            if (p_cs && !spi_cs_n) begin
                if (seen) chk_m(gapc >= DIV, "R8 chip-select gap", 64'(gapc), 64'(DIV));
                bitn = 0; cap = '0; hi = 0; viol = 0;
                spi_miso = miso_bit(0);
            end
            if (!spi_cs_n) begin
                if (spi_sck) hi++;
                if (!p_sck && spi_sck) begin
                    if (bitn < cur_ntx * 8) cap = {cap[62:0], spi_mosi};
                    bitn++;
                end
                if (p_sck && !spi_sck) spi_miso = miso_bit(bitn);
                if (p_sck && spi_sck && spi_mosi != p_mosi) viol++;
            end
            if (!p_cs && spi_cs_n) begin
                if (exp_q.size() == 0) begin
                    chk_m(1'b0, "R12 unexpected frame", 64'(bitn), 64'd0);
                end else begin
                    it = exp_q.pop_front();
                    chk_m(bitn == (it.ntx + it.nrx) * 8, "R6 SCK pulse count", 64'(bitn), 64'((it.ntx + it.nrx) * 8));
                    chk_m(hi == bitn * (DIV / 2), "R9 SCK high time", 64'(hi), 64'(bitn * (DIV / 2)));
                    chk_m(cap == (it.s >> (64 - 8 * it.ntx)), "R2 R4 transmitted bytes", cap, it.s >> (64 - 8 * it.ntx));
                    chk_m(viol == 0, "R7 MOSI changed while SCK high", 64'(viol), 64'd0);
                end
                seen = 1; gapc = 0;
            end
            if (spi_cs_n) gapc++;
            p_cs = spi_cs_n; p_sck = spi_sck; p_mosi = spi_mosi;
        end
    end

    // Driver: one command, pushes its expectation, then checks the register side
    task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input logic [31:0] dinit,
                           input int ntx, input int nrx, input logic [31:0] resp, input bit poke);
        logic [31:0] v, expd, ctrl;
        wr(2'd1, dinit);
        wr(2'd0, {a, op});
        cur_ntx = ntx; cur_nrx = nrx; cur_resp = resp;
        exp_q.push_back('{ntx, nrx, order(op, a, dinit)});
        ctrl = 32'(ntx) | (32'(nrx) << 8);
        wr(2'd2, ctrl | 32'h0001_0000);
        rd(2'd2, v);
        chk_d(v[17] == 1'b1, "R10 busy after start", 64'(v[17]), 64'd1);
        if (poke) begin
            repeat (8) @(negedge clk);
            wr(2'd1, 32'hDEAD_BEEF);
            wr(2'd0, 32'hFFFF_FFFF);
            wr(2'd2, 32'h0001_0008);
        end
        do rd(2'd2, v); while (v[17]);
        chk_d(v == ctrl, "R13 R10 control readback after done", 64'(v), 64'(ctrl));
        expd = dinit;
        for (int j = 0; j < nrx; j++) expd[8*j +: 8] = resp[8*j +: 8];
        rd(2'd1, v);
        chk_d(v == expd, "R5 data register after receive", 64'(v), 64'(expd));
        if (poke) begin
            rd(2'd0, v);
            chk_d(v == {a, op}, "R12 command register after busy write", 64'(v), 64'({a, op}));
        end
    endtask

    task automatic try_reject(input logic [31:0] ctrl, input string why);
        logic [31:0] v;
        wr(2'd2, ctrl | 32'h0001_0000);
        rd(2'd2, v);
        chk_d(v[17] == 1'b0, {"R11 busy stays low: ", why}, 64'(v[17]), 64'd0);
        repeat (12) @(negedge clk);
        chk_d(spi_cs_n == 1'b1, {"R11 no frame: ", why}, 64'(spi_cs_n), 64'd1);
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_d(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 serial pins idle", {spi_cs_n, spi_sck}, 2'b10);
        rd(2'd0, v); chk_d(v == 0, "R1 command reset", 64'(v), 0);
        rd(2'd1, v); chk_d(v == 0, "R1 data reset", 64'(v), 0);
        rd(2'd2, v); chk_d(v == 0, "R1 control reset", 64'(v), 0);

        run_cmd(8'h03, 24'h123456, 32'h1122_3344, 4, 4, 32'hA1B2_C3D4, 0);   // R3 read, four bytes
        run_cmd(8'h02, 24'hABCDEF, 32'hDDCC_BBAA, 8, 0, 32'h0,        0);   // R4 full write
        run_cmd(8'h05, 24'h000000, 32'hFFFF_FFFF, 1, 1, 32'h0000_005A, 0);  // R5 one lane only
        run_cmd(8'h9F, 24'h000000, 32'h7700_0000, 1, 3, 32'h00C2_2017, 0);  // R6 three receive bytes
        run_cmd(8'h01, 24'h5A0000, 32'h0000_0000, 2, 2, 32'h0000_8001, 0);  // R2 truncated order
        run_cmd(8'h06, 24'h000000, 32'h0BAD_F00D, 1, 0, 32'h0,        0);   // R3 opcode only
        run_cmd(8'h0B, 24'h0F0E0D, 32'h4433_2211, 5, 2, 32'h0000_C3A5, 1);  // R12 writes mid-frame

        try_reject(32'h0010_0004, "mode field");
        try_reject(32'h0100_0004, "slave field");
        try_reject(32'h0000_0000, "tx count 0");
        try_reject(32'h0000_0009, "tx count 9");
        try_reject(32'h0000_0501, "rx count 5");

        repeat (20) @(negedge clk);
        chk_d(exp_q.size() == 0, "R6 every expected frame seen", 64'(exp_q.size()), 0);
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        wd_fail = 1;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        report();
        $finish;
    end
endmodule